// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the 16-bit program counter and works out the address of the next instruction. It sees each decoded instruction word once, on a cycle where `instrValid` is high. It adds one to the PC for every instruction. It resolves conditional branches against the current negative/zero/positive flags and performs register-indirect jumps. It also runs service calls, which fetch a new PC from a vector table in memory.

Each service call raises a read request carrying a vector address that is zero-extended from eight bits. The block then waits for memory to answer. The word that comes back is loaded into the PC. On the cycle after the call is accepted, the block writes the incremented PC to link register R7, so that the service routine can return to the instruction after the call. The next PC comes from one of three sources: the increment, a single address adder (shared by branches and jumps), or the memory data bus.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pc` is the start address parameter (default 0x3000), and `vecReq` and `linkWe` are low. A reset during a pending service call abandons that call.
- R2: On a cycle with `instrValid` low and no service call pending, `pc` keeps its value.
- R3: An accepted instruction whose opcode `instr[15:12]` is none of 0000, 1100 or 1111 sets `pc` to `pc+1` on the next cycle.
- R4: Opcode 0000 is a branch. `instr[11:9]` is a mask over the flags, with bit 11 selecting negative, bit 10 zero and bit 9 positive, and `flags` is ordered {N,Z,P}. If any selected flag is set, the next `pc` is `pc+1` plus the sign-extended `instr[8:0]`.
- R5: A branch whose mask selects no set flag, including a mask of 000, sets `pc` to `pc+1`.
- R6: Opcode 1100 is a jump. `baseSel` continuously shows `instr[8:6]`, and the next `pc` is `regData`.
- R7: Opcode 1111 is a service call. On the next cycle `pc` is `pc+1`, `vecReq` is high, and `vecAddr` is `{8'h00, instr[7:0]}`. `linkWe` is high for exactly that one cycle, with `linkData` equal to the incremented PC.
- R8: While `vecReq` is high, `instrValid` is ignored and `pc` holds. On a cycle where `memReady` is high, the next cycle has `pc` equal to the `memData` sampled on that cycle and `vecReq` low.
- R9: All address arithmetic wraps modulo 2^16. The branch offset covers -256 to +255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| flags | input | 3 | Condition flags {N,Z,P} |
| regData | input | 16 | Register value read at `baseSel` |
| memData | input | 16 | Memory read data for the vector fetch |
| memReady | input | 1 | `memData` is valid this cycle |
| pc | output | 16 | Program counter |
| baseSel | output | 3 | Register index for the jump base |
| vecReq | output | 1 | Vector-table read request |
| vecAddr | output | 16 | Zero-extended vector address |
| linkWe | output | 1 | Write strobe for link register R7 |
| linkData | output | 16 | Return address written to R7 |

## Verification
Some properties are checked on every cycle by the assertions. These cover holding the PC while the vector read is pending, loading the bus word on the ready cycle, the one-cycle link pulse and its agreement with the PC, and jump targets. Other behaviour can only be shown by the bench's scenarios. That covers the branch decision for each mask/flag combination, the offset extremes, wrap-around at the top of the address space, and a reset arriving in the middle of a call. There the reference model's PC is compared against the design on every cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    PC_SRC_INC   = 2'd0,
    PC_SRC_ADDER = 2'd1,
    PC_SRC_BUS   = 2'd2
  } pcSrc_e;

  typedef struct packed {
    logic   ldPc;
    pcSrc_e pcSrc;
    logic   baseIsReg;
    logic   ldMar;
    logic   ldLink;
  } pcStrobe_t;

  localparam logic [3:0] OP_BRANCH = 4'b0000;
  localparam logic [3:0] OP_JUMP   = 4'b1100;
  localparam logic [3:0] OP_CALL   = 4'b1111;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int FLAG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [3:0]        opcode,
  input  logic [FLAG_W-1:0] condMask,
  input  logic [FLAG_W-1:0] flags,
  input  logic              memReady,
  output pcStrobe_t         strb,
  output logic              waiting
);

  logic takeBranch;
  logic waitNext;

  assign takeBranch = |(condMask & flags);

  always_comb begin
    strb          = '0;
    strb.pcSrc    = PC_SRC_INC;
    waitNext      = waiting;
    if (waiting) begin
      if (memReady) begin
        strb.ldPc  = 1'b1;
        strb.pcSrc = PC_SRC_BUS;
        waitNext   = 1'b0;
      end
    end else if (instrValid) begin
      strb.ldPc = 1'b1;
      unique case (opcode)
        OP_BRANCH: strb.pcSrc = takeBranch ? PC_SRC_ADDER : PC_SRC_INC;
        OP_JUMP: begin
          strb.pcSrc     = PC_SRC_ADDER;
          strb.baseIsReg = 1'b1;
        end
        OP_CALL: begin
          strb.ldMar  = 1'b1;
          strb.ldLink = 1'b1;
          waitNext    = 1'b1;
        end
        default: strb.pcSrc = PC_SRC_INC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) waiting <= 1'b0;
    else     waiting <= waitNext;
  end

  AST_WAIT_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (waiting && !memReady) |=> waiting); // R8
  AST_CALL_ENTERS_WAIT: assert property (@(posedge clk) disable iff (rst)
    strb.ldLink |=> waiting); // R7

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              OFF_W      = 9,
  parameter int              VEC_W      = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobe_t         strb,
  input  logic [OFF_W-1:0]  offset,
  input  logic [VEC_W-1:0]  vector,
  input  logic [ADDR_W-1:0] regData,
  input  logic [ADDR_W-1:0] busData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData
);

  localparam int EXT_W  = ADDR_W - OFF_W;
  localparam int VPAD_W = ADDR_W - VEC_W;

  logic [ADDR_W-1:0] pcInc;
  logic [ADDR_W-1:0] adderBase;
  logic [ADDR_W-1:0] adderOff;
  logic [ADDR_W-1:0] adderOut;
  logic [ADDR_W-1:0] pcNext;

  assign pcInc     = pc + ADDR_W'(1);
  assign adderBase = strb.baseIsReg ? regData : pcInc;
  assign adderOff  = strb.baseIsReg ? '0 : {{EXT_W{offset[OFF_W-1]}}, offset};
  assign adderOut  = adderBase + adderOff;

  always_comb begin
    unique case (strb.pcSrc)
      PC_SRC_ADDER: pcNext = adderOut;
      PC_SRC_BUS:   pcNext = busData;
      default:      pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= START_ADDR;
      mar      <= '0;
      linkWe   <= 1'b0;
      linkData <= '0;
    end else begin
      if (strb.ldPc)  pc  <= pcNext;
      if (strb.ldMar) mar <= {{VPAD_W{1'b0}}, vector};
      linkWe <= strb.ldLink;
      if (strb.ldLink) linkData <= pcInc;
    end
  end

  AST_LINK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    linkWe |=> !linkWe); // R7
  AST_LINK_MATCHES_PC: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> (linkData == pc)); // R7
  AST_PC_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !strb.ldPc |=> $stable(pc)); // R2

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [15:0]       instr,
  input  logic [2:0]        flags,
  input  logic [ADDR_W-1:0] regData,
  input  logic [ADDR_W-1:0] memData,
  input  logic              memReady,
  output logic [ADDR_W-1:0] pc,
  output logic [2:0]        baseSel,
  output logic              vecReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData
);

  pcStrobe_t strb;
  logic      waiting;

  assign baseSel = instr[8:6];
  assign vecReq  = waiting;

  pcu_ctrl #(.FLAG_W(3)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .instrValid(instrValid),
    .opcode    (instr[15:12]),
    .condMask  (instr[11:9]),
    .flags     (flags),
    .memReady  (memReady),
    .strb      (strb),
    .waiting   (waiting)
  );

  pcu_datapath #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (9),
    .VEC_W     (8),
    .START_ADDR(START_ADDR)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .offset  (instr[8:0]),
    .vector  (instr[7:0]),
    .regData (regData),
    .busData (memData),
    .pc      (pc),
    .mar     (vecAddr),
    .linkWe  (linkWe),
    .linkData(linkData)
  );

  AST_WAIT_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    (vecReq && !memReady) |=> ($stable(pc) && vecReq)); // R8
  AST_RETURN_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
    (vecReq && memReady) |=> ((pc == $past(memData)) && !vecReq)); // R8
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !vecReq && instr[15:12] == OP_JUMP) |=> (pc == $past(regData))); // R6
  AST_CALL_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> vecReq); // R7

endmodule

// File: tb/test_pcu_top.sv
module test_pcu_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [2:0]  flags = 3'b000;
  logic [15:0] regData = 16'h0000;
  logic [15:0] memData = 16'h0000;
  logic        memReady = 1'b0;
  logic [15:0] pc;
  logic [2:0]  baseSel;
  logic        vecReq;
  logic [15:0] vecAddr;
  logic        linkWe;
  logic [15:0] linkData;

  int checks = 0;
  int fails  = 0;
  string lastTag = "R1";

  // behavioural reference state
  logic [15:0] mPc = 16'h3000;
  logic        mWait = 1'b0;
  logic [15:0] mVec = 16'h0000;
  logic        mLinkWe = 1'b0;
  logic [15:0] mLinkData = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcu_top i_pcu_top (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .flags(flags), .regData(regData), .memData(memData), .memReady(memReady),
    .pc(pc), .baseSel(baseSel), .vecReq(vecReq), .vecAddr(vecAddr),
    .linkWe(linkWe), .linkData(linkData)
  );

  always @(posedge clk) begin
    logic [15:0] nxt;
    if (rst) begin
      mPc = 16'h3000; mWait = 1'b0; mLinkWe = 1'b0; mLinkData = 16'h0000; mVec = 16'h0000;
    end else begin
      mLinkWe = 1'b0;
      if (mWait) begin
        if (memReady) begin
          mPc = memData;
          mWait = 1'b0;
        end
      end else if (instrValid) begin
        nxt = mPc + 16'd1;
        if (instr[15:12] == 4'b0000) begin
          if ((instr[11:9] & flags) != 3'b000)
            mPc = nxt + {{7{instr[8]}}, instr[8:0]};
          else
            mPc = nxt;
        end else if (instr[15:12] == 4'b1100) begin
          mPc = regData;
        end else if (instr[15:12] == 4'b1111) begin
          mPc = nxt;
          mWait = 1'b1;
          mVec = {8'h00, instr[7:0]};
          mLinkWe = 1'b1;
          mLinkData = nxt;
        end else begin
          mPc = nxt;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(lastTag, "pc", pc, mPc);
    check(lastTag, "vecReq", {15'd0, vecReq}, {15'd0, mWait});
    if (mWait) check(lastTag, "vecAddr", vecAddr, mVec);
    check(lastTag, "linkWe", {15'd0, linkWe}, {15'd0, mLinkWe});
    if (mLinkWe) check(lastTag, "linkData", linkData, mLinkData);
    check("R6", "baseSel", {13'd0, baseSel}, {13'd0, instr[8:6]});
  endtask

  task automatic step(input logic r, input logic v, input logic [15:0] ins,
                      input logic [2:0] f, input logic [15:0] rd,
                      input logic mr, input logic [15:0] md, input string tag);
    @(negedge clk);
    compareAll();
    rst = r; instrValid = v; instr = ins; flags = f; regData = rd;
    memReady = mr; memData = md;
    lastTag = tag;
  endtask

  task automatic op(input logic [15:0] ins, input logic [2:0] f, input logic [15:0] rd, input string tag);
    step(1'b0, 1'b1, ins, f, rd, 1'b0, 16'h0000, tag);
  endtask

  initial begin
    step(1'b1, 1'b0, 16'h0000, 3'b000, 16'h0, 1'b0, 16'h0, "R1");
    step(1'b1, 1'b0, 16'h0000, 3'b000, 16'h0, 1'b0, 16'h0, "R1");
    step(1'b0, 1'b0, 16'h0000, 3'b000, 16'h0, 1'b0, 16'h0, "R1");
    step(1'b0, 1'b0, 16'h1234, 3'b111, 16'h0, 1'b0, 16'h0, "R2");
    step(1'b0, 1'b0, 16'hC1C0, 3'b111, 16'h5555, 1'b0, 16'h0, "R2");
    // four sequential instructions: 0x3000 -> 0x3004
    op(16'hE3FD, 3'b001, 16'h0, "R3");
    op(16'h1462, 3'b001, 16'h0, "R3");
    op(16'h2610, 3'b100, 16'h0, "R3");
    op(16'h6840, 3'b010, 16'h0, "R3");
    // BRz +5 at 0x3004 with Z set -> 0x300A
    op(16'h0405, 3'b010, 16'h0, "R4");
    // jump to 0x3009, then BRnzp -6 -> 0x3004
    op(16'hC0C0, 3'b001, 16'h3009, "R6");
    op(16'h0FFA, 3'b001, 16'h0, "R4");
    // not taken: mask 000, and negative mask with P flag
    op(16'h01FF, 3'b111, 16'h0, "R5");
    op(16'h0805, 3'b001, 16'h0, "R5");
    op(16'h0205, 3'b100, 16'h0, "R5");
    // offset extremes
    op(16'h0F00, 3'b100, 16'h0, "R9");
    op(16'h0EFF, 3'b001, 16'h0, "R9");
    // wrap at top of address space
    op(16'hC1C0, 3'b010, 16'hFFFF, "R6");
    op(16'h5020, 3'b010, 16'h0, "R9");
    op(16'h0E02, 3'b010, 16'h0, "R4");
    op(16'hC080, 3'b010, 16'h0000, "R6");
    op(16'h0FFE, 3'b100, 16'h0, "R9");
    // service call with a slow vector read; instrValid pulses ignored
    op(16'hF025, 3'b010, 16'h0, "R7");
    op(16'hC1C0, 3'b010, 16'h1111, "R8");
    op(16'h0FFF, 3'b111, 16'h0, "R8");
    step(1'b0, 1'b1, 16'h1000, 3'b001, 16'h0, 1'b1, 16'h0520, "R8");
    op(16'h1000, 3'b001, 16'h0, "R3");
    // call answered on the first waiting cycle; memReady held high
    step(1'b0, 1'b1, 16'hF0FF, 3'b001, 16'h0, 1'b1, 16'hBEEF, "R7");
    step(1'b0, 1'b0, 16'h0000, 3'b001, 16'h0, 1'b1, 16'h4242, "R8");
    step(1'b0, 1'b0, 16'h0000, 3'b001, 16'h0, 1'b0, 16'h0, "R2");
    // reset during a pending call
    op(16'hF021, 3'b001, 16'h0, "R7");
    step(1'b0, 1'b0, 16'h0000, 3'b001, 16'h0, 1'b0, 16'h0, "R8");
    step(1'b1, 1'b0, 16'h0000, 3'b001, 16'h0, 1'b0, 16'h0, "R1");
    step(1'b0, 1'b0, 16'h0000, 3'b001, 16'h0, 1'b1, 16'h7777, "R1");
    op(16'h9000, 3'b001, 16'h0, "R3");
    step(1'b0, 1'b0, 16'h0000, 3'b001, 16'h0, 1'b0, 16'h0, "R3");
    @(negedge clk);
    compareAll();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule